// File: doc/BRIEF.md
# Bidirectional Single-Side SAR Conversion Controller

This block sequences one conversion of a differential charge-redistribution ADC. A start pulse launches a conversion. The block then reads one comparator decision per clock and drives a switch-state vector for the capacitor bank on each side of the array. Each switch selects ground, the reference, or the mid-supply level. After the input has been sampled onto the bottom plates, the most significant capacitor on each side sits at ground and every other capacitor sits at the reference. The first decision lifts one most significant capacitor to the reference, on the side that reads lower. Each later decision drops exactly one capacitor, on the side that reads higher only. The final capacitor drops to the mid-supply level instead of ground, so it contributes half a step, and one extra comparison resolves the last bit.

The bank carries an extra capacitor that repeats the weight of the next binary one, so a wrong early decision can be recovered. Twelve comparisons produce an 11-bit code. The code is the weighted sum of all decisions less half the redundant weight, clamped to the code range. A one-cycle done pulse marks the code, and the switches return to the sampling arrangement at the same moment.

Top module: `bss_sar_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, capacitor 0 on both sides reads ground and all other capacitors read reference. Done is low and the code is 0. Each capacitor i occupies bits [2i+1:2i] of a side vector, with capacitor 0 the largest. The encodings are 00 ground, 01 reference, 11 mid-supply.
- R2: A start pulse is accepted only when idle. A start during a conversion changes neither the switch sequence, the done timing nor the code.
- R3: At the first comparison, cmp_i=1 (positive top plate higher) moves capacitor 0 of the negative side from ground to reference. cmp_i=0 does the same on the positive side.
- R4: At comparisons 2 through 10, capacitor k-1 moves from reference to ground, on the positive side when cmp_i=1 and on the negative side otherwise. The other side is unchanged.
- R5: At comparison 11, the last capacitor moves from reference to mid-supply, on the side that R4's rule selects.
- R6: Exactly one capacitor field changes after each of the first 11 comparisons.
- R7: Done is high for exactly one cycle, 12 clock edges after the edge that accepted start. The code holds its value until the next done.
- R8: The code equals the sum of decision weights 1024, 512, 256, 128, 64, 32, 16 (redundant), 16, 8, 4, 2 and 1 for the twelve comparisons in order, minus 8, clamped to 0..2047. With an ideal comparator it lies within one LSB of (v+2048)/2 rounded down, where v is the differential input in half-LSB units over -2048..2047.
- R9: A wrong decision at the fourth comparison, taken while the residue is within 8 half-LSB units of zero, is corrected by the redundant capacitor. The code stays within one LSB of ideal.
- R10: In the done cycle, all switches are back in the sampling arrangement of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-conversion pulse |
| cmp_i | input | 1 | Comparator decision, 1 when positive top plate is higher |
| sw_p_o | output | 22 | Positive side switch states, 2 bits per capacitor |
| sw_n_o | output | 22 | Negative side switch states, 2 bits per capacitor |
| code_o | output | 11 | Converted code |
| done_o | output | 1 | One-cycle marker of a new code |

## Verification
The hardest condition to reach from the ports is redundant recovery. An ideal comparator never makes the early mistake that the extra capacitor exists to absorb. The bench comparator is therefore a charge model of the array that can invert its answer at the fourth comparison whenever the residue lies close to zero. Sweeping the input over a dense grid drives many conversions through that corrupted decision, and each resulting code is checked against the ideal code.

// File: rtl/bss_pkg.sv
package bss_pkg;

    // Switch state of one capacitor bottom plate; every legal move flips one bit
    typedef enum logic [1:0] {
        SW_GND = 2'b00,
        SW_REF = 2'b01,
        SW_VCM = 2'b11
    } sw_e;

    // Capacitor size in units, index 0 largest; the last one is switched to mid-supply
    function automatic int cap_units(input int i, input int nbits, input int red_pos);
        if (i == nbits - 1)  return 2;
        if (i < red_pos)     return 1 << (nbits - 2 - i);
        if (i == red_pos)    return 1 << (nbits - 2 - red_pos);
        return 1 << (nbits - 1 - i);
    endfunction

    // Code weight of the decision taken at comparison k (not the final one)
    function automatic int code_weight(input int k, input int nbits, input int red_pos);
        if (k == nbits - 1) return cap_units(k, nbits, red_pos);
        return 2 * cap_units(k, nbits, red_pos);
    endfunction

endpackage

// File: rtl/bss_step_seq.sv
module bss_step_seq #(
    parameter int NSTEP = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic [NSTEP-1:0] step_o
);
    logic [NSTEP-1:0] ptr_q;
    logic             busy;
    logic             last;

    assign busy   = |ptr_q;
    assign last   = ptr_q[NSTEP-1];
    assign step_o = ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (!busy)
            ptr_q <= {{(NSTEP-1){1'b0}}, start_i};
        else
            ptr_q <= ptr_q << 1;
    end

    // R2: at most one comparison position active
    a_r2_onehot_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ptr_q));

    // R2: a running conversion is never restarted by start
    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && !ptr_q[0]));

    // R7: conversion ends right after the final comparison
    a_r7_ends_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
endmodule

// File: rtl/bss_switch_bank.sv
module bss_switch_bank
    import bss_pkg::*;
#(
    parameter int NCAP  = 11,
    parameter int NSTEP = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSTEP-1:0]  step_i,
    input  logic              dec_i,
    output logic [2*NCAP-1:0] sw_p_o,
    output logic [2*NCAP-1:0] sw_n_o
);
    localparam logic [2*NCAP-1:0] SAMPLE_CFG = {{(NCAP-1){2'b01}}, 2'b00};

    logic finish;
    assign finish = step_i[NSTEP-1];

    for (genvar gi = 0; gi < NCAP; gi++) begin : g_cap
        localparam sw_e INIT = (gi == 0) ? SW_GND : SW_REF;
        localparam sw_e MOVE = (gi == 0) ? SW_REF : ((gi == NCAP - 1) ? SW_VCM : SW_GND);
        sw_e p_q;
        sw_e n_q;

        always_ff @(posedge clk) begin
            if (rst || finish) begin
                p_q <= INIT;
                n_q <= INIT;
            end else if (step_i[gi]) begin
                // first step lifts the lower side; later steps drop the higher side
                if ((gi == 0) ? !dec_i : dec_i)
                    p_q <= MOVE;
                else
                    n_q <= MOVE;
            end
        end

        assign sw_p_o[2*gi +: 2] = p_q;
        assign sw_n_o[2*gi +: 2] = n_q;
    end

    // R6: one switching event per comparison cycle
    a_r6_single_event: assert property (@(posedge clk) disable iff (rst)
        (|step_i[NSTEP-2:0]) |=>
        ($countones({sw_p_o ^ $past(sw_p_o), sw_n_o ^ $past(sw_n_o)}) == 1));

    // R3: first decision high leaves the positive side untouched
    a_r3_lift_negative: assert property (@(posedge clk) disable iff (rst)
        (step_i[0] && dec_i) |=> $stable(sw_p_o));

    // R3: first decision low leaves the negative side untouched
    a_r3_lift_positive: assert property (@(posedge clk) disable iff (rst)
        (step_i[0] && !dec_i) |=> $stable(sw_n_o));

    // R4: later decisions touch the higher side only
    a_r4_drop_positive: assert property (@(posedge clk) disable iff (rst)
        ((|step_i[NSTEP-2:1]) && dec_i) |=> $stable(sw_n_o));

    a_r4_drop_negative: assert property (@(posedge clk) disable iff (rst)
        ((|step_i[NSTEP-2:1]) && !dec_i) |=> $stable(sw_p_o));

    // R10: sampling arrangement restored when the conversion completes
    a_r10_restore: assert property (@(posedge clk) disable iff (rst)
        finish |=> (sw_p_o == SAMPLE_CFG && sw_n_o == SAMPLE_CFG));

    // R1: idle arrangement held while no comparison runs
    a_r1_idle_cfg: assert property (@(posedge clk) disable iff (rst)
        (step_i == '0) |-> (sw_p_o == SAMPLE_CFG && sw_n_o == SAMPLE_CFG));
endmodule

// File: rtl/bss_code_fold.sv
module bss_code_fold
    import bss_pkg::*;
#(
    parameter int NBITS   = 11,
    parameter int RED_POS = 6,
    parameter int NSTEP   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTEP-1:0] step_i,
    input  logic             dec_i,
    output logic [NBITS-1:0] code_o,
    output logic             done_o
);
    localparam int CODE_MAX = (1 << NBITS) - 1;
    localparam int OFFSET   = cap_units(RED_POS, NBITS, RED_POS);

    logic [NSTEP-2:0] dec_q;
    logic [NSTEP-1:0] dec_all;
    logic [NBITS-1:0] code_d;
    logic [NBITS-1:0] code_q;
    logic             done_q;

    assign dec_all = {dec_i, dec_q};

    // Weighted sum with the redundant offset removed, clamped to the code range
    always_comb begin
        int acc;
        acc = -OFFSET;
        for (int k = 0; k < NSTEP - 1; k++)
            if (dec_all[k]) acc += code_weight(k, NBITS, RED_POS);
        if (dec_all[NSTEP-1]) acc += 1;
        if (acc < 0)
            code_d = '0;
        else if (acc > CODE_MAX)
            code_d = '1;
        else
            code_d = NBITS'(acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q  <= '0;
            code_q <= '0;
            done_q <= 1'b0;
        end else begin
            for (int k = 0; k < NSTEP - 1; k++)
                if (step_i[k]) dec_q[k] <= dec_i;
            done_q <= step_i[NSTEP-1];
            if (step_i[NSTEP-1]) code_q <= code_d;
        end
    end

    assign code_o = code_q;
    assign done_o = done_q;

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: the code only moves together with done
    a_r7_code_hold: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(code_q));
endmodule

// File: rtl/bss_sar_ctrl.sv
module bss_sar_ctrl #(
    parameter int NBITS   = 11,
    parameter int RED_POS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               cmp_i,
    output logic [2*NBITS-1:0] sw_p_o,
    output logic [2*NBITS-1:0] sw_n_o,
    output logic [NBITS-1:0]   code_o,
    output logic               done_o
);
    localparam int NCAP  = NBITS;
    localparam int NSTEP = NBITS + 1;

    logic [NSTEP-1:0] step;

    bss_step_seq #(.NSTEP(NSTEP)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .step_o  (step)
    );

    bss_switch_bank #(.NCAP(NCAP), .NSTEP(NSTEP)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .dec_i  (cmp_i),
        .sw_p_o (sw_p_o),
        .sw_n_o (sw_n_o)
    );

    bss_code_fold #(.NBITS(NBITS), .RED_POS(RED_POS), .NSTEP(NSTEP)) u_fold (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .dec_i  (cmp_i),
        .code_o (code_o),
        .done_o (done_o)
    );

    // R10: done always coincides with the sampling arrangement
    a_r10_done_cfg: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (sw_p_o == {{(NCAP-1){2'b01}}, 2'b00} && sw_n_o == {{(NCAP-1){2'b01}}, 2'b00}));
endmodule

// File: tb/bss_sar_ctrl_tb.sv
module bss_sar_ctrl_tb;
    localparam int NB = 11;
    localparam logic [2*NB-1:0] SAMPLE = {{(NB-1){2'b01}}, 2'b00};
    localparam int CAPS [NB] = '{512, 256, 128, 64, 32, 16, 8, 8, 4, 2, 2};

    typedef struct packed {
        logic [NB-1:0] code;
        logic ok_first;
        logic ok_mid;
        logic ok_last;
        logic ok_one;
        logic ok_time;
        logic ok_rest;
    } conv_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cmp;
    logic cmp_flip;
    logic [2*NB-1:0] sw_p, sw_n;
    logic [NB-1:0] code;
    logic done;

    int v_in = 0;
    int cur_step = -1;
    int err_k = -1;
    int flips = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    bss_sar_ctrl u_dut (
        .clk(clk), .rst(rst), .start_i(start), .cmp_i(cmp),
        .sw_p_o(sw_p), .sw_n_o(sw_n), .code_o(code), .done_o(done)
    );

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'b01:   return 2;
            2'b11:   return 1;
            default: return 0;
        endcase
    endfunction

    // Charge model: differential top-plate level in half-LSB units
    function automatic int diff_of(input int v, input logic [2*NB-1:0] p, input logic [2*NB-1:0] n);
        int d;
        d = v;
        for (int i = 0; i < NB; i++)
            d += CAPS[i] * (lvl(p[2*i +: 2]) - lvl(n[2*i +: 2]));
        return d;
    endfunction

    always_comb begin
        int d;
        d = diff_of(v_in, sw_p, sw_n);
        cmp_flip = (cur_step == err_k) && (d >= -8) && (d <= 8);
        cmp = (d >= 0) ^ cmp_flip;
    end

    function automatic int n_changed(input logic [2*NB-1:0] a, input logic [2*NB-1:0] b);
        int c;
        c = 0;
        for (int i = 0; i < NB; i++)
            if (a[2*i +: 2] != b[2*i +: 2]) c++;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // One conversion; records step-by-step observations
    task automatic convert(input int v, input int ek, input bit poke, output conv_t r);
        logic [2*NB-1:0] sp, sn, ep, en;
        logic dec;
        v_in = v;
        err_k = ek;
        r = '{code: '0, ok_first: 1'b1, ok_mid: 1'b1, ok_last: 1'b1,
              ok_one: 1'b1, ok_time: 1'b1, ok_rest: 1'b1};
        @(negedge clk); start = 1'b1; cur_step = -1;
        @(negedge clk); start = 1'b0; cur_step = 0;
        #1;
        if (sw_p != SAMPLE || sw_n != SAMPLE) r.ok_rest = 1'b0;
        if (done) r.ok_time = 1'b0;
        sp = sw_p; sn = sw_n; dec = cmp;
        if (cmp_flip) flips++;
        for (int j = 1; j <= NB; j++) begin
            if (poke && j == 4) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            ep = sp; en = sn;
            if (j == 1) begin
                if (dec) en[1:0] = 2'b01; else ep[1:0] = 2'b01;
            end else begin
                if (dec) ep[2*(j-1) +: 2] = (j == NB) ? 2'b11 : 2'b00;
                else     en[2*(j-1) +: 2] = (j == NB) ? 2'b11 : 2'b00;
            end
            if (sw_p != ep || sw_n != en) begin
                if (j == 1) r.ok_first = 1'b0;
                else if (j == NB) r.ok_last = 1'b0;
                else r.ok_mid = 1'b0;
            end
            if (n_changed(sw_p, sp) + n_changed(sw_n, sn) != 1) r.ok_one = 1'b0;
            if (done) r.ok_time = 1'b0;
            sp = sw_p; sn = sw_n;
            cur_step = j;
            #1;
            dec = cmp;
            if (cmp_flip) flips++;
        end
        @(negedge clk);
        cur_step = -1;
        if (!done) r.ok_time = 1'b0;
        if (sw_p != SAMPLE || sw_n != SAMPLE) r.ok_rest = 1'b0;
        r.code = code;
        @(negedge clk);
        if (done || code != r.code) r.ok_time = 1'b0;
    endtask

    task automatic t_reset();
        chk(sw_p == SAMPLE && sw_n == SAMPLE, "R1 idle switch arrangement", int'(sw_p[1:0]), 0);
        chk(done == 1'b0, "R1 done low after reset", int'(done), 0);
        chk(code == '0, "R1 code zero after reset", int'(code), 0);
    endtask

    task automatic t_known(input int v, input int exp_code);
        conv_t r;
        convert(v, -1, 1'b0, r);
        chk(int'(r.code) == exp_code, "R8 exact code", int'(r.code), exp_code);
        chk(r.ok_first, "R3 first switching move", 0, 1);
        chk(r.ok_mid, "R4 single-side drops", 0, 1);
        chk(r.ok_last, "R5 mid-supply last move", 0, 1);
        chk(r.ok_time, "R7 done timing and hold", 0, 1);
    endtask

    task automatic t_sweep();
        conv_t r;
        int bad_code = 0, bad_first = 0, bad_mid = 0, bad_last = 0;
        int bad_one = 0, bad_time = 0, bad_rest = 0;
        for (int v = -2048; v <= 2047; v++) begin
            int ideal, e;
            convert(v, -1, 1'b0, r);
            ideal = (v + 2048) / 2;
            e = int'(r.code) - ideal;
            if (e > 1 || e < -1) begin
                if (bad_code == 0) $display("sweep mismatch at v=%0d code=%0d ideal=%0d", v, r.code, ideal);
                bad_code++;
            end
            if (!r.ok_first) bad_first++;
            if (!r.ok_mid) bad_mid++;
            if (!r.ok_last) bad_last++;
            if (!r.ok_one) bad_one++;
            if (!r.ok_time) bad_time++;
            if (!r.ok_rest) bad_rest++;
        end
        chk(bad_code == 0, "R8 sweep codes within one LSB", bad_code, 0);
        chk(bad_first == 0, "R3 sweep first move", bad_first, 0);
        chk(bad_mid == 0, "R4 sweep middle moves", bad_mid, 0);
        chk(bad_last == 0, "R5 sweep mid-supply move", bad_last, 0);
        chk(bad_one == 0, "R6 sweep one change per comparison", bad_one, 0);
        chk(bad_time == 0, "R7 sweep done pulse", bad_time, 0);
        chk(bad_rest == 0, "R10 sweep restore at done", bad_rest, 0);
    endtask

    task automatic t_start_ignored();
        conv_t a, b;
        convert(301, -1, 1'b0, a);
        convert(301, -1, 1'b1, b);
        chk(b.code == a.code, "R2 start during conversion leaves code", int'(b.code), int'(a.code));
        chk(b.ok_time && b.ok_first && b.ok_mid && b.ok_last, "R2 start during conversion leaves sequence", 0, 1);
    endtask

    task automatic t_redundancy();
        conv_t r;
        int bad = 0;
        flips = 0;
        for (int v = -2048; v <= 2047; v += 3) begin
            int ideal, e;
            convert(v, 3, 1'b0, r);
            ideal = (v + 2048) / 2;
            e = int'(r.code) - ideal;
            if (e > 1 || e < -1) bad++;
        end
        chk(flips > 0, "R9 wrong early decisions injected", flips, 1);
        chk(bad == 0, "R9 codes recovered within one LSB", bad, 0);
        err_k = -1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_known(0, 1024);
        t_known(2047, 2047);
        t_known(-2048, 0);
        t_start_ignored();
        t_sweep();
        t_redundancy();
        finish_run();
    end
endmodule